// File: doc/BRIEF.md
# UART Receive Buffer with Interrupt Threshold, Read Watchdog and RTS Pacing

This block sits between a UART bit-level deserializer and the host. The deserializer hands it each assembled character with three status flags: framing error, parity error and break. The block stores them in a FIFO whose depth is picked at run time (a shallow or a deep setting, 8 or 256 by default). It raises a receive interrupt when the fill level reaches a threshold chosen by a 2-bit code. A read watchdog also raises the interrupt when data sits unread for too long. Each host read strobe pops the head entry. The data and status of the head are always visible at the outputs.

Flow control is optional. When the receiver is allowed to pace the far end, a start bit that arrives while the FIFO is full pulls the RTS output low. RTS comes back as soon as a slot frees. A character that completes while the FIFO is full waits in a single hold slot. A second start bit while that slot is still occupied records an overrun and throws away the character that follows. Error status is reported either for the head character alone or as a sticky OR over the characters that reached the head since the last error-clear command.

Top module: `uart_rx_fifo_wd`

## Requirements
- R1: During reset, and in the first cycle after it, rx_ready, rx_irq, overrun and all three status outputs are 0 and rts_active is 0. From the second cycle after release, rts_active follows rts_request.
- R2: With sel_deep=0, rx_irq is 1 exactly when the stored count is at least the level chosen by irq_level: 0→1, 1→3, 2→6, 3→8.
- R3: With sel_deep=1, rx_irq is 1 exactly when the count is at least 1, 128, 192 or 256 for irq_level 0, 1, 2 or 3.
- R4: Entries leave in the order they arrived. rx_data shows the head byte while rx_ready is 1. A pop on an empty FIFO changes nothing. sel_deep may change only while the FIFO is empty.
- R5: With wdog_en=1 and the FIFO non-empty, the 64th bit_tick without a pop raises rx_irq. A pop clears that interrupt and restarts the count. With wdog_en=0 the watchdog never raises rx_irq.
- R6: The watchdog counts bit_tick only while the FIFO holds data. Ticks seen while it is empty do not count.
- R7: With rts_auto=1, start_seen while the FIFO is full drives rts_active to 0. It returns to rts_request one cycle after the pop that frees a slot. rts_request itself is never altered.
- R8: With rts_auto=0, rts_active follows rts_request with one cycle of delay, whatever the fill level.
- R9: A character completing while the FIFO is full goes to the hold slot and enters the FIFO after the next pop, in order. start_seen while the FIFO is full and the hold slot is occupied sets overrun and discards the next character. overrun stays set until err_clear or rx_rst.
- R10: With err_block=0, the status bits {stat_brk, stat_pe, stat_fe} are the flags of the head entry, and 0 when the FIFO is empty.
- R11: With err_block=1, each status bit is the OR of that flag over every entry that became head since the last err_clear or rx_rst. Those two inputs are the only way to clear it.
- R12: rx_rst empties the FIFO and the hold slot and clears overrun, the watchdog and the accumulated status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_rst | input | 1 | Receiver reset command: flushes buffer and status |
| char_valid | input | 1 | Strobe: an assembled character is present |
| char_data | input | 8 | Character byte |
| char_fe | input | 1 | Framing error flag of the character |
| char_pe | input | 1 | Parity error flag of the character |
| char_brk | input | 1 | Break flag of the character |
| start_seen | input | 1 | Strobe: a valid start bit was detected |
| bit_tick | input | 1 | One pulse per bit time of the receiver 1x clock |
| host_pop | input | 1 | Host read strobe, pops the head entry |
| sel_deep | input | 1 | 0 = shallow FIFO, 1 = deep FIFO |
| irq_level | input | 2 | Interrupt fill level code |
| wdog_en | input | 1 | Enables the read watchdog |
| rts_auto | input | 1 | Lets the receiver negate RTS when full |
| rts_request | input | 1 | Host RTS request bit |
| err_block | input | 1 | 0 = per-character status, 1 = accumulated status |
| err_clear | input | 1 | Error reset command |
| rx_data | output | 8 | Head byte |
| rx_ready | output | 1 | FIFO holds at least one entry |
| stat_fe | output | 1 | Framing error status |
| stat_pe | output | 1 | Parity error status |
| stat_brk | output | 1 | Break status |
| overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt |
| rts_active | output | 1 | RTS asserted (1) or negated (0) |

## Verification
Every output is a register loaded from next-state logic. Fill level, head data, status, overrun, interrupt and RTS negation therefore change at the clock edge that samples the strobe. The watchdog interrupt appears at the edge that samples the 64th counted tick. The one output due later is the return of RTS, one edge after the freeing pop. The bench drives each strobe for exactly one cycle from a falling edge and compares at the following falling edge, so each check sits in the first cycle in which its result is due. The RTS return is checked once before and once after its extra edge.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // One buffered character: status flags above the data byte.
  typedef struct packed {
    logic       brk;
    logic       pe;
    logic       fe;
    logic [7:0] data;
  } rxq_entry_t;

  // Interrupt fill level selection codes.
  typedef enum logic [1:0] {
    LVL_ANY  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_FULL = 2'd3
  } rxq_level_e;

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH_SMALL = 8,
  parameter int DEPTH_LARGE = 256,
  localparam int AW = $clog2(DEPTH_LARGE),
  localparam int CW = $clog2(DEPTH_LARGE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          deep,
  input  logic          wr_en,
  input  rxq_entry_t    wr_word,
  input  logic          rd_en,
  output logic [CW-1:0] count_q_o,
  output logic [CW-1:0] count_d_o,
  output logic          full_o,
  output logic [7:0]    head_data_o,
  output rxq_entry_t    head_d_o,
  output logic          arrive_d_o
);

  rxq_entry_t    mem [DEPTH_LARGE];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, ptr_mask;
  logic [CW-1:0] count_q, count_d, depth_cur;
  rxq_entry_t    head_q, head_d;
  logic          do_wr, do_rd, empty, full;

  assign depth_cur = deep ? CW'(DEPTH_LARGE) : CW'(DEPTH_SMALL);
  assign ptr_mask  = deep ? AW'(DEPTH_LARGE - 1) : AW'(DEPTH_SMALL - 1);
  assign full      = (count_q == depth_cur);
  assign empty     = (count_q == '0);
  assign do_wr     = wr_en & ~full & ~flush;
  assign do_rd     = rd_en & ~empty & ~flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_wr) wr_ptr_d = (wr_ptr_q + AW'(1)) & ptr_mask;
      if (do_rd) rd_ptr_d = (rd_ptr_q + AW'(1)) & ptr_mask;
      case ({do_wr, do_rd})
        2'b10:   count_d = count_q + CW'(1);
        2'b01:   count_d = count_q - CW'(1);
        default: count_d = count_q;
      endcase
    end
  end

  // Head for the next cycle: bypass when the write lands on the new head slot.
  always_comb begin
    if (flush)                             head_d = '0;
    else if (do_wr && wr_ptr_q == rd_ptr_d) head_d = wr_word;
    else                                   head_d = mem[rd_ptr_d];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      head_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      head_q   <= head_d;
    end
  end

  assign count_q_o   = count_q;
  assign count_d_o   = count_d;
  assign full_o      = full;
  assign head_data_o = head_q.data;
  assign head_d_o    = head_d;
  assign arrive_d_o  = (count_d != '0) & (do_rd | (empty & do_wr));

  // R4: fill level never passes the selected depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= depth_cur);

  // R4: a lone pop on an empty FIFO leaves it empty
  a_r4_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_en && count_q == '0 && !wr_en) |=> count_q == '0);

endmodule

// File: rtl/uart_rxq_wdog.sv
module uart_rxq_wdog #(
  parameter int TICKS = 64,
  localparam int TW = $clog2(TICKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic en,
  input  logic active,
  input  logic pop,
  input  logic tick,
  output logic pend_d_o,
  output logic pend_q_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (flush || !en || pop || !active) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (tick && !pend_q) begin
      if (cnt_q == TW'(TICKS - 1)) begin
        cnt_d  = '0;
        pend_d = 1'b1;
      end else begin
        cnt_d = cnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_d_o = pend_d;
  assign pend_q_o = pend_q;

  // R5: a host read clears a pending watchdog request
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    pop |=> !pend_q);

  // R6: an empty buffer leaves nothing pending
  a_r6_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
    (!active && !tick) |=> !pend_q);

endmodule

// File: rtl/uart_rxq_errstat.sv
module uart_rxq_errstat (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       clr,
  input  logic       block,
  input  logic       arrive_d,
  input  logic       present_d,
  input  logic [2:0] flags_d,
  output logic [2:0] stat_q_o
);

  logic [2:0] acc_q, acc_d, stat_q, stat_d;

  always_comb begin
    acc_d = (clr || flush) ? 3'b000 : acc_q;
    if (arrive_d) acc_d = acc_d | flags_d;
    stat_d = block ? acc_d : (present_d ? flags_d : 3'b000);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      stat_q <= '0;
    end else begin
      acc_q  <= acc_d;
      stat_q <= stat_d;
    end
  end

  assign stat_q_o = stat_q;

  // R10: per-character status is quiet on an empty buffer
  a_r10_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    (!block && !present_d) |=> stat_q == 3'b000);

  // R11: a clear with no new head empties the accumulated status
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    (block && clr && !arrive_d) |=> stat_q == 3'b000);

endmodule

// File: rtl/uart_rx_fifo_wd.sv
module uart_rx_fifo_wd
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH_SMALL = 8,
  parameter int DEPTH_LARGE = 256,
  parameter int SMALL_LVL1  = 3,
  parameter int SMALL_LVL2  = 6,
  parameter int WDOG_TICKS  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_rst,
  input  logic       char_valid,
  input  logic [7:0] char_data,
  input  logic       char_fe,
  input  logic       char_pe,
  input  logic       char_brk,
  input  logic       start_seen,
  input  logic       bit_tick,
  input  logic       host_pop,
  input  logic       sel_deep,
  input  logic [1:0] irq_level,
  input  logic       wdog_en,
  input  logic       rts_auto,
  input  logic       rts_request,
  input  logic       err_block,
  input  logic       err_clear,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       stat_fe,
  output logic       stat_pe,
  output logic       stat_brk,
  output logic       overrun,
  output logic       rx_irq,
  output logic       rts_active
);

  localparam int CW = $clog2(DEPTH_LARGE + 1);

  function automatic logic [CW-1:0] level_of(input logic deep, input logic [1:0] code);
    case (rxq_level_e'(code))
      LVL_ANY:  level_of = CW'(1);
      LVL_LOW:  level_of = deep ? CW'(DEPTH_LARGE / 2)     : CW'(SMALL_LVL1);
      LVL_HIGH: level_of = deep ? CW'(3 * DEPTH_LARGE / 4) : CW'(SMALL_LVL2);
      default:  level_of = deep ? CW'(DEPTH_LARGE)         : CW'(DEPTH_SMALL);
    endcase
  endfunction

  rxq_entry_t    in_word, hold_q, hold_d, st_word, head_d;
  logic          hold_v_q, hold_v_d, drop_q, drop_d, ovr_q, ovr_d;
  logic          st_wr, full, arrive_d, pend_d, pend_q;
  logic [CW-1:0] count_q, count_d;
  logic [2:0]    stat_q;
  logic          blk_q, blk_d, rts_q, irq_q, irq_d;

  assign in_word = '{brk: char_brk, pe: char_pe, fe: char_fe, data: char_data};

  // Ingress: direct write, hold slot, discard and overrun bookkeeping.
  always_comb begin
    st_wr    = 1'b0;
    st_word  = in_word;
    hold_d   = hold_q;
    hold_v_d = hold_v_q;
    drop_d   = drop_q;
    ovr_d    = err_clear ? 1'b0 : ovr_q;
    if (hold_v_q && !full) begin
      st_wr    = 1'b1;
      st_word  = hold_q;
      hold_v_d = 1'b0;
    end
    if (char_valid) begin
      if (drop_q) begin
        drop_d = 1'b0;
      end else if (hold_v_q && full) begin
        ovr_d = 1'b1;
      end else if (!full && !hold_v_q) begin
        st_wr   = 1'b1;
        st_word = in_word;
      end else begin
        hold_v_d = 1'b1;
        hold_d   = in_word;
      end
    end
    if (start_seen && full && hold_v_q) begin
      ovr_d  = 1'b1;
      drop_d = 1'b1;
    end
    if (rx_rst) begin
      st_wr    = 1'b0;
      hold_v_d = 1'b0;
      drop_d   = 1'b0;
      ovr_d    = 1'b0;
    end
  end

  uart_rxq_store #(
    .DEPTH_SMALL(DEPTH_SMALL),
    .DEPTH_LARGE(DEPTH_LARGE)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .flush      (rx_rst),
    .deep       (sel_deep),
    .wr_en      (st_wr),
    .wr_word    (st_word),
    .rd_en      (host_pop),
    .count_q_o  (count_q),
    .count_d_o  (count_d),
    .full_o     (full),
    .head_data_o(rx_data),
    .head_d_o   (head_d),
    .arrive_d_o (arrive_d)
  );

  uart_rxq_wdog #(.TICKS(WDOG_TICKS)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .flush   (rx_rst),
    .en      (wdog_en),
    .active  (count_q != '0),
    .pop     (host_pop),
    .tick    (bit_tick),
    .pend_d_o(pend_d),
    .pend_q_o(pend_q)
  );

  uart_rxq_errstat u_err (
    .clk      (clk),
    .rst      (rst),
    .flush    (rx_rst),
    .clr      (err_clear),
    .block    (err_block),
    .arrive_d (arrive_d),
    .present_d(count_d != '0),
    .flags_d  ({head_d.brk, head_d.pe, head_d.fe}),
    .stat_q_o (stat_q)
  );

  // RTS pacing: negated on a start bit while full, released once not full.
  assign blk_d = !rx_rst && rts_auto && full && ((start_seen) || blk_q);
  assign irq_d = (count_d >= level_of(sel_deep, irq_level)) | pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      drop_q   <= 1'b0;
      ovr_q    <= 1'b0;
      blk_q    <= 1'b0;
      rts_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      hold_v_q <= hold_v_d;
      drop_q   <= drop_d;
      ovr_q    <= ovr_d;
      blk_q    <= blk_d;
      rts_q    <= rts_request & ~blk_d;
      irq_q    <= irq_d;
    end
  end

  assign rx_ready   = (count_q != '0);
  assign {stat_brk, stat_pe, stat_fe} = stat_q;
  assign overrun    = ovr_q;
  assign rx_irq     = irq_q;
  assign rts_active = rts_q;

  // R2/R3/R5: the interrupt never fires on an empty buffer
  a_r2_irq_needs_data: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_ready);

  // R7: start bit while full with pacing enabled negates RTS
  a_r7_rts_drop: assert property (@(posedge clk) disable iff (rst)
    (rts_auto && start_seen && full && !rx_rst) |=> !rts_active);

  // R8: without pacing RTS mirrors the request bit
  a_r8_rts_follow: assert property (@(posedge clk) disable iff (rst)
    !rts_auto |=> rts_active == $past(rts_request));

  // R9: overrun only rises on a start bit or a character strobe
  a_r9_ovr_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(start_seen || char_valid));

  // R12: receiver reset empties the buffer
  a_r12_flush: assert property (@(posedge clk) disable iff (rst)
    rx_rst |=> !rx_ready && !overrun);

endmodule

// File: tb/uart_rx_fifo_wd_tb_top.sv
module uart_rx_fifo_wd_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, rx_rst = 0, char_valid = 0, char_fe = 0, char_pe = 0, char_brk = 0;
  logic [7:0] char_data = 0;
  logic       start_seen = 0, bit_tick = 0, host_pop = 0, sel_deep = 0;
  logic [1:0] irq_level = 0;
  logic       wdog_en = 0, rts_auto = 0, rts_request = 1, err_block = 0, err_clear = 0;
  logic [7:0] rx_data;
  logic       rx_ready, stat_fe, stat_pe, stat_brk, overrun, rx_irq, rts_active;

  int n_cmp = 0;
  int n_bad = 0;

  uart_rx_fifo_wd dut_i (
    .clk(clk), .rst(rst), .rx_rst(rx_rst), .char_valid(char_valid), .char_data(char_data),
    .char_fe(char_fe), .char_pe(char_pe), .char_brk(char_brk), .start_seen(start_seen),
    .bit_tick(bit_tick), .host_pop(host_pop), .sel_deep(sel_deep), .irq_level(irq_level),
    .wdog_en(wdog_en), .rts_auto(rts_auto), .rts_request(rts_request), .err_block(err_block),
    .err_clear(err_clear), .rx_data(rx_data), .rx_ready(rx_ready), .stat_fe(stat_fe),
    .stat_pe(stat_pe), .stat_brk(stat_brk), .overrun(overrun), .rx_irq(rx_irq),
    .rts_active(rts_active)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stat3();
    return {29'd0, stat_brk, stat_pe, stat_fe};
  endfunction

  // Each task starts at a falling edge and ends at the next one.
  task automatic push(input int d, input int f);
    char_valid = 1; char_data = d[7:0];
    {char_brk, char_pe, char_fe} = f[2:0];
    @(negedge clk);
    char_valid = 0; {char_brk, char_pe, char_fe} = 3'b000;
  endtask
  task automatic pop();   host_pop = 1;   @(negedge clk); host_pop = 0;   endtask
  task automatic start(); start_seen = 1; @(negedge clk); start_seen = 0; endtask
  task automatic tick();  bit_tick = 1;   @(negedge clk); bit_tick = 0;   endtask
  task automatic flush(); rx_rst = 1;     @(negedge clk); rx_rst = 0;     endtask
  task automatic eclr();  err_clear = 1;  @(negedge clk); err_clear = 0;  endtask

  function automatic int thr(input bit deep, input int lvl);
    if (lvl == 0) return 1;
    if (deep) return 64 * (lvl + 1);
    return (lvl == 1) ? 3 : (lvl == 2) ? 6 : 8;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values, RTS follows request from the next cycle
    check("R1 ready", rx_ready, 0);
    check("R1 irq", rx_irq, 0);
    check("R1 stat", stat3(), 0);
    check("R1 overrun", overrun, 0);
    check("R1 rts", rts_active, 0);
    @(negedge clk);
    check("R1 rts follows", rts_active, 1);

    // R2: shallow thresholds while filling and draining
    sel_deep = 0;
    for (int lvl = 0; lvl < 4; lvl++) begin
      irq_level = lvl[1:0];
      flush();
      check("R2 empty", rx_irq, 0);
      for (int n = 1; n <= 8; n++) begin
        push(n, 0);
        check("R2 fill", rx_irq, int'(n >= thr(0, lvl)));
      end
      for (int n = 7; n >= 0; n--) begin
        pop();
        check("R2 drain", rx_irq, int'(n >= thr(0, lvl)));
      end
    end

    // R3 and R4: deep thresholds and order over 256 entries
    sel_deep = 1;
    for (int lvl = 0; lvl < 4; lvl++) begin
      irq_level = lvl[1:0];
      flush();
      for (int n = 1; n <= 256; n++) begin
        push((n * 7 + lvl) & 255, 0);
        check("R3 fill", rx_irq, int'(n >= thr(1, lvl)));
      end
      for (int n = 1; n <= 256; n++) begin
        check("R4 deep order", rx_data, (n * 7 + lvl) & 255);
        pop();
      end
      check("R4 deep empty", rx_ready, 0);
    end
    sel_deep = 0;
    flush();

    // R4 and R10: shallow order with per-character flags
    irq_level = 0;
    for (int i = 0; i < 8; i++) push((i * 37 + 5) & 255, i);
    for (int i = 0; i < 8; i++) begin
      check("R4 ready", rx_ready, 1);
      check("R4 data", rx_data, (i * 37 + 5) & 255);
      check("R10 head flags", stat3(), i);
      pop();
    end
    check("R4 empty", rx_ready, 0);
    check("R10 empty stat", stat3(), 0);
    pop();
    check("R4 pop on empty", rx_ready, 0);
    push(8'hA5, 0);
    check("R4 after empty pop", rx_data, 8'hA5);
    check("R4 one entry", rx_ready, 1);
    pop();

    // R5: watchdog on the 64th tick, cleared by a read
    irq_level = 3; wdog_en = 1;
    flush();
    push(8'h11, 0);
    for (int t = 1; t <= 64; t++) begin
      tick();
      check("R5 wdog count", rx_irq, int'(t == 64));
    end
    pop();
    check("R5 read clears", rx_irq, 0);
    // R6: ticks while empty are ignored
    for (int t = 0; t < 100; t++) tick();
    check("R6 empty no irq", rx_irq, 0);
    push(8'h22, 0);
    for (int t = 1; t <= 64; t++) begin
      tick();
      check("R6 fresh count", rx_irq, int'(t == 64));
    end
    push(8'h23, 0);
    check("R5 write keeps pending", rx_irq, 1);
    pop();
    check("R5 pop clears", rx_irq, 0);
    for (int t = 1; t <= 64; t++) begin
      tick();
      check("R5 restart", rx_irq, int'(t == 64));
    end
    wdog_en = 0;
    @(negedge clk);
    check("R5 disabled", rx_irq, 0);
    for (int t = 0; t < 100; t++) tick();
    check("R5 disabled ticks", rx_irq, 0);
    flush();

    // R7 and R9: RTS pacing with the hold slot
    rts_auto = 1; irq_level = 0;
    for (int i = 0; i < 8; i++) push(8'h40 + i, 0);
    check("R7 full no start", rts_active, 1);
    start();
    check("R7 negated", rts_active, 0);
    push(8'h48, 0);
    check("R7 held", rts_active, 0);
    check("R9 no overrun yet", overrun, 0);
    check("R7 pop data", rx_data, 8'h40);
    pop();
    check("R7 one cycle lag", rts_active, 0);
    @(negedge clk);
    check("R7 reasserted", rts_active, 1);
    for (int i = 1; i <= 8; i++) begin
      check("R9 hold order", rx_data, 8'h40 + i);
      pop();
    end
    check("R9 drained", rx_ready, 0);

    // R8: no pacing when disabled
    rts_auto = 0;
    for (int i = 0; i < 8; i++) push(i, 0);
    start();
    check("R8 ignores full", rts_active, 1);
    rts_request = 0;
    @(negedge clk);
    check("R8 follows low", rts_active, 0);
    rts_request = 1;
    flush();
    check("R12 flush ready", rx_ready, 0);

    // R9: overrun discards the character after the second start
    rts_auto = 1;
    for (int i = 0; i < 8; i++) push(8'h60 + i, 0);
    start();
    push(8'h68, 0);
    start();
    check("R9 overrun set", overrun, 1);
    push(8'h69, 0);
    for (int i = 0; i <= 8; i++) begin
      check("R9 survivors", rx_data, 8'h60 + i);
      pop();
    end
    check("R9 newest dropped", rx_ready, 0);
    check("R9 sticky", overrun, 1);
    eclr();
    check("R9 cleared", overrun, 0);
    rts_auto = 0;

    // R11: block mode accumulation
    err_block = 1;
    flush();
    push(8'h01, 3'b001);
    check("R11 first head", stat3(), 1);
    push(8'h02, 3'b010);
    check("R11 not head yet", stat3(), 1);
    push(8'h03, 3'b000);
    pop();
    check("R11 accumulate", stat3(), 3);
    pop();
    check("R11 clean head keeps", stat3(), 3);
    eclr();
    check("R11 err clear", stat3(), 0);
    pop();
    check("R11 empty", stat3(), 0);
    push(8'h04, 3'b100);
    check("R11 break", stat3(), 4);
    // R12: receiver reset clears everything
    flush();
    check("R12 stat", stat3(), 0);
    check("R12 ready", rx_ready, 0);
    check("R12 irq", rx_irq, 0);

    summary();
    $finish;
  end

endmodule